// File: doc/BRIEF.md
# Sensor Threshold Alarm Monitor

This block watches a stream of digitized sensor readings and keeps one registered alarm flag for each of seven channels. Channel 0 is a temperature sensor. Channels 1 to 6 are supply voltages: the internal, auxiliary and block-RAM supplies of the programmable logic, then the internal, auxiliary and DDR I/O supplies of the processor side. Each reading arrives as a channel index and a 12-bit code, qualified by a valid strobe. A separate over-temperature flag also watches the temperature readings, using a threshold pair of its own.

Each channel has a lower and an upper threshold, and software loads them through a small write port. A voltage channel raises its alarm while a reading lies outside its window, and drops the alarm as soon as a reading falls back inside. The temperature alarm and the over-temperature flag use hysteresis. They set only above the upper threshold and clear only below the lower threshold. Between the two they hold their state.

Top module: `sensor_alarm_monitor`

## Requirements
- R1: On a voltage channel (index 1 to 6, driving `alarm` bits 1 to 6), a valid reading that is above the channel's upper threshold or below its lower threshold sets that alarm bit.
- R2: A valid reading on a voltage channel that lies within its window clears that alarm bit. The window includes both bounds, so a code equal to a threshold counts as inside. Comparisons are unsigned.
- R3: The temperature alarm (`alarm` bit 0, reading index 0) sets only on a reading above its upper threshold. A reading below its lower threshold never sets it.
- R4: The temperature alarm clears only on a reading below its lower threshold. A reading between the two thresholds, bounds included, leaves it unchanged.
- R5: `overtemp` follows the same hysteresis rules as the temperature alarm. It works on channel-0 readings and uses its own threshold pair, and it is independent of `alarm` bit 0.
- R6: An alarm bit changes only on a valid reading for its own channel. The following leave every output unchanged: readings with `smp_valid` low, and readings on index 7, which is unused.
- R7: Reset clears all alarm bits and `overtemp`. It also sets every lower threshold to 0 and every upper threshold to 0xFFF, so no reading raises an alarm until the thresholds are programmed.
- R8: A write with `cfg_we` high loads `cfg_data` into a threshold. `cfg_addr[3:1]` selects the pair: 0 to 6 are the channels and 7 is the over-temperature pair. `cfg_addr[0]` selects the bound: 1 for upper, 0 for lower. A write takes effect for readings from the next clock onward.
- R9: The outputs are registered. They show the effect of a reading one clock after the edge on which `smp_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Reading strobe |
| smp_chan | input | 3 | Channel index of the reading |
| smp_code | input | 12 | Unsigned reading code |
| cfg_we | input | 1 | Threshold write enable |
| cfg_addr | input | 4 | Threshold select: pair in [3:1], upper/lower in [0] |
| cfg_data | input | 12 | Threshold value |
| alarm | output | 7 | Per-channel alarm flags, bit 0 temperature |
| overtemp | output | 1 | Over-temperature flag |

## Verification
The assertions assume that `smp_valid`, `smp_chan` and `smp_code` are known on every sampled edge after reset. They also assume that a threshold written in a given cycle applies only to later readings. The bench meets both conditions: it drives every input from time zero and changes inputs only on the falling clock edge. It issues threshold writes in cycles of their own, apart from the readings that rely on them. Some thresholds are placed so that a reading lands exactly on a bound, which probes both sides of each comparison.

// File: rtl/sensor_alarm_monitor.sv
module sensor_alarm_monitor #(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 7,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [IDX_W-1:0]  smp_chan,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_data,
  output logic [NUM_CH-1:0] alarm,
  output logic              overtemp
);
  localparam int NPAIR  = NUM_CH + 1;
  localparam int OT_IDX = NUM_CH;

  logic [CODE_W-1:0] lo_q [NPAIR];
  logic [CODE_W-1:0] hi_q [NPAIR];
  logic [NPAIR-1:0]  above, below;
  logic [NUM_CH-1:0] hit;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[p] <= '0;
        hi_q[p] <= '1;
      end else if (cfg_we && cfg_addr[ADDR_W-1:1] == IDX_W'(p)) begin
        if (cfg_addr[0]) hi_q[p] <= cfg_data;
        else             lo_q[p] <= cfg_data;
      end
    end
    assign above[p] = smp_code > hi_q[p];
    assign below[p] = smp_code < lo_q[p];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = smp_valid && smp_chan == IDX_W'(i);
    if (i == 0) begin : g_hyst
      always_ff @(posedge clk) begin
        if (!rst_n)                alarm[i] <= 1'b0;
        else if (hit[i] && above[i]) alarm[i] <= 1'b1;
        else if (hit[i] && below[i]) alarm[i] <= 1'b0;
      end
    end else begin : g_win
      always_ff @(posedge clk) begin
        if (!rst_n)      alarm[i] <= 1'b0;
        else if (hit[i]) alarm[i] <= above[i] | below[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       overtemp <= 1'b0;
    else if (hit[0] && above[OT_IDX]) overtemp <= 1'b1;
    else if (hit[0] && below[OT_IDX]) overtemp <= 1'b0;
  end
endmodule

// File: rtl/sensor_alarm_monitor_chk.sv
module sensor_alarm_monitor_chk #(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 7,
  parameter int IDX_W  = 3,
  parameter int NPAIR  = NUM_CH + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [IDX_W-1:0]  smp_chan,
  input logic [CODE_W-1:0] smp_code,
  input logic [NUM_CH-1:0] alarm,
  input logic              overtemp,
  input logic [CODE_W-1:0] lo_q [NPAIR],
  input logic [CODE_W-1:0] hi_q [NPAIR]
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R6
    own_chan_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_valid && smp_chan == IDX_W'(i)) |=> $stable(alarm[i]));
    if (i == 0) begin : g_t
      // R3
      temp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == '0 && smp_code > hi_q[0]) |=> alarm[0]);
      // R4
      temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == '0 && smp_code >= lo_q[0] && smp_code <= hi_q[0])
        |=> $stable(alarm[0]));
    end else begin : g_v
      // R1
      window_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == IDX_W'(i) && (smp_code > hi_q[i] || smp_code < lo_q[i]))
        |=> alarm[i]);
      // R2
      window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == IDX_W'(i) && smp_code >= lo_q[i] && smp_code <= hi_q[i])
        |=> !alarm[i]);
    end
  end
  // R5
  overtemp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_chan == '0) |=> $stable(overtemp));
  // R5
  overtemp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_chan == '0 && smp_code > hi_q[NUM_CH]) |=> overtemp);
endmodule

bind sensor_alarm_monitor sensor_alarm_monitor_chk #(
  .CODE_W(CODE_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W), .NPAIR(NUM_CH + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
  .smp_code(smp_code), .alarm(alarm), .overtemp(overtemp),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/tb_sensor_alarm_monitor.sv
module tb_sensor_alarm_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [2:0] smp_chan = '0;
  logic [11:0] smp_code = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic [6:0] alarm;
  logic overtemp;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_lo [8];
  logic [11:0] m_hi [8];
  logic [6:0] m_alarm;
  logic m_ot;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  sensor_alarm_monitor dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_code(smp_code), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .alarm(alarm), .overtemp(overtemp)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    smp_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    if (a[0]) m_hi[a[3:1]] = d; else m_lo[a[3:1]] = d;
    q.push_back('{{m_ot, m_alarm}, "R8"});
    @(negedge clk);
    cfg_we = 1'b0;
    q.push_back('{{m_ot, m_alarm}, "R8"});
  endtask

  task automatic smp(input logic v, input logic [2:0] ch, input logic [11:0] c, input string req);
    @(negedge clk);
    smp_valid = v; smp_chan = ch; smp_code = c;
    if (v && ch == 3'd0) begin
      if (c > m_hi[0]) m_alarm[0] = 1'b1;
      else if (c < m_lo[0]) m_alarm[0] = 1'b0;
      if (c > m_hi[7]) m_ot = 1'b1;
      else if (c < m_lo[7]) m_ot = 1'b0;
    end else if (v && ch != 3'd7) begin
      m_alarm[ch] = (c > m_hi[ch]) || (c < m_lo[ch]);
    end
    q.push_back('{{m_ot, m_alarm}, req});
  endtask

  // R9: each reading's result is compared on the edge after it is sampled
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({overtemp, alarm}, it.exp, it.req);
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_lo[k] = '0; m_hi[k] = '1; end
    m_alarm = '0; m_ot = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({overtemp, alarm}, 8'h00, "R7");
    // R7: full-scale defaults raise nothing
    for (int k = 0; k < 8; k++) begin
      smp(1'b1, 3'(k), 12'h000, "R7");
      smp(1'b1, 3'(k), 12'hFFF, "R7");
    end
    // R8 / R1 / R2: channel 1 window 0x400..0x800
    wr(4'd2, 12'h400); wr(4'd3, 12'h800);
    smp(1'b1, 3'd1, 12'h900, "R1");
    smp(1'b1, 3'd1, 12'h800, "R2");
    smp(1'b1, 3'd1, 12'h3FF, "R1");
    smp(1'b1, 3'd1, 12'h400, "R2");
    smp(1'b1, 3'd1, 12'h801, "R1");
    smp(1'b1, 3'd1, 12'h500, "R2");
    // R3 / R4: temperature 0x300..0x600
    wr(4'd0, 12'h300); wr(4'd1, 12'h600);
    smp(1'b1, 3'd0, 12'h100, "R3");
    smp(1'b1, 3'd0, 12'h600, "R3");
    smp(1'b1, 3'd0, 12'h601, "R3");
    smp(1'b1, 3'd0, 12'h400, "R4");
    smp(1'b1, 3'd0, 12'h300, "R4");
    smp(1'b1, 3'd0, 12'h2FF, "R4");
    smp(1'b1, 3'd0, 12'h500, "R4");
    // R5: over-temperature 0x500..0x700
    wr(4'd14, 12'h500); wr(4'd15, 12'h700);
    smp(1'b1, 3'd0, 12'h701, "R5");
    smp(1'b1, 3'd0, 12'h650, "R5");
    smp(1'b1, 3'd0, 12'h500, "R5");
    smp(1'b1, 3'd0, 12'h4FF, "R5");
    smp(1'b1, 3'd0, 12'h200, "R5");
    // R6: other channels, invalid, index 7
    wr(4'd4, 12'h100); wr(4'd5, 12'h200);
    smp(1'b1, 3'd2, 12'h300, "R1");
    smp(1'b0, 3'd2, 12'h150, "R6");
    smp(1'b1, 3'd7, 12'h150, "R6");
    smp(1'b1, 3'd3, 12'h150, "R6");
    smp(1'b1, 3'd2, 12'h150, "R2");
    // R8: processor-side DDR supply pair, then bounds swapped roles
    wr(4'd13, 12'hA00); wr(4'd12, 12'h900);
    smp(1'b1, 3'd6, 12'h950, "R8");
    smp(1'b1, 3'd6, 12'hA01, "R8");
    smp(1'b1, 3'd6, 12'h8FF, "R8");
    smp(1'b1, 3'd6, 12'hA00, "R8");
    smp(1'b1, 3'd4, 12'hFFF, "R8");
    smp(1'b0, 3'd0, 12'h000, "R9");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule